// File: doc/BRIEF.md
# DDR memory initialization sequencer

This block is a hardware state machine that brings a DDR1 or DDR2 SDRAM from power-on to a usable state. After a start pulse it walks through a fixed bring-up script, presenting one command at a time on a command port (a one-hot command code, a mode-register select and a 16-bit mode value). Each command is held until the command port answers with a one-cycle done pulse. When the script ends, the block produces the refresh-interval word for the periodic refresh engine and raises `init_done`.

Two straps shape the run. `strap_ddr2` picks the DDR2 script, which is longer and includes a separate off-chip-driver calibration default step and exit step on the extended mode register. With the strap low the short DDR1 script runs. `strap_ref40` picks the refresh interval for a 40 MHz reference instead of 25 MHz. In DDR2 mode a DDR2 configuration word is written once before the first command. Both straps are captured at start and held for the whole run.

The states are IDLE (wait for start), CFG (one-cycle DDR2 configuration write), ISSUE (command held on the port), GAP (one idle cycle between commands), REFR (one-cycle refresh word write) and DONE (initialization complete). The transitions are: IDLE to CFG on start with DDR2 strapped, IDLE to ISSUE on start with DDR1 strapped, CFG to ISSUE, ISSUE to GAP on done for a step that is not the last, ISSUE to REFR on done for the last step, GAP to ISSUE, REFR to DONE. DONE is left only by reset, and reset sends every state to IDLE.

Top module: `dram_bringup_seq`

## Requirements
- R1: `cmd_code` is one-hot while `cmd_valid` is high and zero otherwise: bit 0 loads MR, bit 1 loads EMR, bit 2 is auto-refresh, bit 3 is precharge-all, bit 4 loads EMR2, bit 5 loads EMR3. `mode_sel` is 0 for MR, 1 for EMR, 2 for EMR2, 3 for EMR3, and `mode_sel` and `mode_val` are 0 for precharge and auto-refresh.
- R2: With DDR2 strapped the commands are, in order: precharge-all; EMR2 load 0x000; EMR3 load 0x000; EMR load 0x000; MR load 0x100; precharge-all; auto-refresh; auto-refresh; MR load 0xA33; EMR load 0x382; EMR load 0x402.
- R3: With DDR1 strapped the commands are, in order: precharge-all; MR load 0x133; EMR load 0x002; precharge-all; MR load 0x033.
- R4: In DDR2 mode `ddr2_cfg_we` pulses for exactly one cycle, the cycle right after start is accepted and before the first command, with `ddr2_cfg_word` = 0x0A59 (write latency 2 in bits 13:10, ODT enable bit 9, tFAW 22 in bits 7:2, enable bit 0). In DDR1 mode it never pulses.
- R5: One cycle after the last command's done, `refresh_we` pulses for one cycle with `refresh_word` holding the enable flag at bit 14 and the interval in bits 9:0: 0x4270 (624) with the 40 MHz strap, 0x4186 (390) otherwise; the word stays on `refresh_word` while `init_done` is high.
- R6: A command stays on the port, unchanged, until `cmd_done` is sampled high; the cycle after a done `cmd_valid` is low; `cmd_done` while `cmd_valid` is low has no effect.
- R7: A synchronous active-high reset returns the block to IDLE with `init_done`, `cmd_valid`, `cmd_code`, `ddr2_cfg_we` and `refresh_we` low, also in the middle of a script.
- R8: The straps are sampled only on the start cycle; changing them during a run changes neither the script nor the refresh word.
- R9: `init_done` rises the cycle after the refresh write and stays high until reset; start pulses after that issue no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the script when idle |
| strap_ddr2 | input | 1 | 1 selects the DDR2 script, 0 the DDR1 script |
| strap_ref40 | input | 1 | 1 selects the 40 MHz refresh interval, 0 the 25 MHz one |
| cmd_done | input | 1 | One-cycle completion pulse from the command port |
| cmd_valid | output | 1 | A command is presented |
| cmd_code | output | 6 | One-hot command code |
| mode_sel | output | 2 | Mode register targeted by a load |
| mode_val | output | 16 | Value for a mode register load |
| ddr2_cfg_we | output | 1 | One-cycle write strobe for the DDR2 configuration word |
| ddr2_cfg_word | output | 16 | DDR2 configuration word, valid with its strobe |
| refresh_we | output | 1 | One-cycle write strobe for the refresh word |
| refresh_word | output | 16 | Refresh enable and interval |
| init_done | output | 1 | Initialization complete |

## Verification
The hardest situation to reach from the ports is a strap change or a stray done pulse arriving in the middle of a script, exactly in the idle gap cycle or in the configuration cycle where the block must ignore it. The stimulus gets there by answering each command after a random delay of zero to three cycles, so back-to-back completions and long holds both occur, while in the randomized runs the straps are re-randomized on every cycle and stray done pulses are thrown in whenever no command is on the port. Directed runs cover all four strap combinations with no noise, a reset in the middle of a script and start pulses after completion.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    localparam int CMD_W  = 6;
    localparam int MODE_W = 16;
    localparam int IDX_W  = 4;
    localparam int WORD_W = 16;

    // one-hot command codes; the command port decodes these bit positions
    localparam logic [CMD_W-1:0] OP_MR   = 6'b000001;
    localparam logic [CMD_W-1:0] OP_EMR  = 6'b000010;
    localparam logic [CMD_W-1:0] OP_AREF = 6'b000100;
    localparam logic [CMD_W-1:0] OP_PALL = 6'b001000;
    localparam logic [CMD_W-1:0] OP_EMR2 = 6'b010000;
    localparam logic [CMD_W-1:0] OP_EMR3 = 6'b100000;

    typedef enum logic [1:0] {
        SEL_MR   = 2'd0,
        SEL_EMR  = 2'd1,
        SEL_EMR2 = 2'd2,
        SEL_EMR3 = 2'd3
    } mreg_sel_t;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        mreg_sel_t         sel;
        logic [MODE_W-1:0] val;
        logic              last;
    } step_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG,
        ST_ISSUE,
        ST_GAP,
        ST_REFR,
        ST_DONE
    } seq_state_t;

    function automatic step_t mk_step(logic [CMD_W-1:0] c, mreg_sel_t s,
                                      logic [MODE_W-1:0] v, logic l);
        step_t r;
        r.cmd  = c;
        r.sel  = s;
        r.val  = v;
        r.last = l;
        return r;
    endfunction

endpackage

// File: rtl/dram_script_rom.sv
module dram_script_rom
    import dram_seq_pkg::*;
(
    input  logic             use_ddr2,
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);

    step_t ddr2_step;
    step_t ddr1_step;

    always_comb begin
        unique case (idx)
            4'd0:    ddr2_step = mk_step(OP_PALL, SEL_MR,   16'h0000, 1'b0);
            4'd1:    ddr2_step = mk_step(OP_EMR2, SEL_EMR2, 16'h0000, 1'b0);
            4'd2:    ddr2_step = mk_step(OP_EMR3, SEL_EMR3, 16'h0000, 1'b0);
            4'd3:    ddr2_step = mk_step(OP_EMR,  SEL_EMR,  16'h0000, 1'b0);
            4'd4:    ddr2_step = mk_step(OP_MR,   SEL_MR,   16'h0100, 1'b0);
            4'd5:    ddr2_step = mk_step(OP_PALL, SEL_MR,   16'h0000, 1'b0);
            4'd6:    ddr2_step = mk_step(OP_AREF, SEL_MR,   16'h0000, 1'b0);
            4'd7:    ddr2_step = mk_step(OP_AREF, SEL_MR,   16'h0000, 1'b0);
            4'd8:    ddr2_step = mk_step(OP_MR,   SEL_MR,   16'h0A33, 1'b0);
            4'd9:    ddr2_step = mk_step(OP_EMR,  SEL_EMR,  16'h0382, 1'b0);
            4'd10:   ddr2_step = mk_step(OP_EMR,  SEL_EMR,  16'h0402, 1'b1);
            default: ddr2_step = mk_step(OP_PALL, SEL_MR,   16'h0000, 1'b1);
        endcase
    end

    always_comb begin
        unique case (idx)
            4'd0:    ddr1_step = mk_step(OP_PALL, SEL_MR,  16'h0000, 1'b0);
            4'd1:    ddr1_step = mk_step(OP_MR,   SEL_MR,  16'h0133, 1'b0);
            4'd2:    ddr1_step = mk_step(OP_EMR,  SEL_EMR, 16'h0002, 1'b0);
            4'd3:    ddr1_step = mk_step(OP_PALL, SEL_MR,  16'h0000, 1'b0);
            4'd4:    ddr1_step = mk_step(OP_MR,   SEL_MR,  16'h0033, 1'b1);
            default: ddr1_step = mk_step(OP_PALL, SEL_MR,  16'h0000, 1'b1);
        endcase
    end

    assign step = use_ddr2 ? ddr2_step : ddr1_step;

endmodule

// File: rtl/dram_cfg_words.sv
module dram_cfg_words
    import dram_seq_pkg::*;
#(
    parameter int REF_SLOW  = 390,
    parameter int REF_FAST  = 624,
    parameter int REF_W     = 10,
    parameter int REF_EN_B  = 14,
    parameter int WR_LAT    = 2,
    parameter int FAW       = 22,
    parameter int ODT_ON    = 1
)(
    input  logic              ref40,
    output logic [WORD_W-1:0] refresh_val,
    output logic [WORD_W-1:0] ddr2_val
);

    localparam logic [WORD_W-1:0] REF_EN   = WORD_W'(1) << REF_EN_B;
    localparam logic [WORD_W-1:0] SLOW_W   = WORD_W'(REF_SLOW & ((1 << REF_W) - 1));
    localparam logic [WORD_W-1:0] FAST_W   = WORD_W'(REF_FAST & ((1 << REF_W) - 1));
    // write latency 13:10, ODT 9, tFAW 7:2, enable 0
    localparam logic [WORD_W-1:0] DDR2_CFG = WORD_W'(((WR_LAT & 15) << 10) |
                                                     ((ODT_ON & 1) << 9) |
                                                     ((FAW & 63) << 2) | 1);

    assign refresh_val = REF_EN | (ref40 ? FAST_W : SLOW_W);
    assign ddr2_val    = DDR2_CFG;

endmodule

// File: rtl/dram_bringup_seq.sv
module dram_bringup_seq
    import dram_seq_pkg::*;
#(
    parameter int REF_SLOW = 390,
    parameter int REF_FAST = 624
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              strap_ddr2,
    input  logic              strap_ref40,
    input  logic              cmd_done,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_code,
    output logic [1:0]        mode_sel,
    output logic [MODE_W-1:0] mode_val,
    output logic              ddr2_cfg_we,
    output logic [WORD_W-1:0] ddr2_cfg_word,
    output logic              refresh_we,
    output logic [WORD_W-1:0] refresh_word,
    output logic              init_done
);

    seq_state_t       state, state_nx;
    logic [IDX_W-1:0] idx, idx_nx;
    logic             ddr2_q, ref40_q;
    step_t            cur;
    logic [WORD_W-1:0] ref_val, cfg_val;

    dram_script_rom u_rom (
        .use_ddr2 (ddr2_q),
        .idx      (idx),
        .step     (cur)
    );

    dram_cfg_words #(
        .REF_SLOW (REF_SLOW),
        .REF_FAST (REF_FAST)
    ) u_words (
        .ref40       (ref40_q),
        .refresh_val (ref_val),
        .ddr2_val    (cfg_val)
    );

    // state register; straps captured only on the start cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            idx     <= '0;
            ddr2_q  <= 1'b0;
            ref40_q <= 1'b0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
            if (state == ST_IDLE && start) begin
                ddr2_q  <= strap_ddr2;
                ref40_q <= strap_ref40;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_nx      = state;
        idx_nx        = idx;
        cmd_valid     = 1'b0;
        cmd_code      = '0;
        mode_sel      = '0;
        mode_val      = '0;
        ddr2_cfg_we   = 1'b0;
        ddr2_cfg_word = '0;
        refresh_we    = 1'b0;
        refresh_word  = '0;
        init_done     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idx_nx = '0;
                if (start) state_nx = strap_ddr2 ? ST_CFG : ST_ISSUE;
            end
            ST_CFG: begin
                ddr2_cfg_we   = 1'b1;
                ddr2_cfg_word = cfg_val;
                state_nx      = ST_ISSUE;
            end
            ST_ISSUE: begin
                cmd_valid = 1'b1;
                cmd_code  = cur.cmd;
                mode_sel  = cur.sel;
                mode_val  = cur.val;
                if (cmd_done) begin
                    if (cur.last) begin
                        state_nx = ST_REFR;
                    end else begin
                        state_nx = ST_GAP;
                        idx_nx   = idx + 1'b1;
                    end
                end
            end
            ST_GAP: state_nx = ST_ISSUE;
            ST_REFR: begin
                refresh_we   = 1'b1;
                refresh_word = ref_val;
                state_nx     = ST_DONE;
            end
            ST_DONE: begin
                refresh_word = ref_val;
                init_done    = 1'b1;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // R1: one command bit at a time, nothing when idle
    assert_onehot_cmd_R1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $onehot(cmd_code));
    assert_quiet_cmd_R1: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> cmd_code == '0);
    // R6: command held until done, then one idle cycle
    assert_hold_cmd_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_code) &&
                                      $stable(mode_sel) && $stable(mode_val)));
    assert_gap_after_done_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_done) |=> !cmd_valid);
    // R4: configuration strobe only in DDR2 mode
    assert_cfg_ddr2_only_R4: assert property (@(posedge clk) disable iff (rst)
        ddr2_cfg_we |-> ddr2_q);
    // R8: captured straps frozen outside idle
    assert_straps_held_R8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> ($stable(ddr2_q) && $stable(ref40_q)));
    // R9: completion is sticky and quiet
    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        init_done |=> (init_done && !cmd_valid));
    // R5: refresh strobe is followed by completion
    assert_refresh_then_done_R5: assert property (@(posedge clk) disable iff (rst)
        refresh_we |=> init_done);

endmodule

// File: tb/dram_bringup_seq_tb.sv
module dram_bringup_seq_tb;

    localparam time CLK_P = 8ns;

    logic        clk = 1'b0;
    logic        rst, start, strap_ddr2, strap_ref40, cmd_done;
    logic        cmd_valid, ddr2_cfg_we, refresh_we, init_done;
    logic [5:0]  cmd_code;
    logic [1:0]  mode_sel;
    logic [15:0] mode_val, ddr2_cfg_word, refresh_word;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    dram_bringup_seq u_dut (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .strap_ddr2    (strap_ddr2),
        .strap_ref40   (strap_ref40),
        .cmd_done      (cmd_done),
        .cmd_valid     (cmd_valid),
        .cmd_code      (cmd_code),
        .mode_sel      (mode_sel),
        .mode_val      (mode_val),
        .ddr2_cfg_we   (ddr2_cfg_we),
        .ddr2_cfg_word (ddr2_cfg_word),
        .refresh_we    (refresh_we),
        .refresh_word  (refresh_word),
        .init_done     (init_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // {code[5:0], sel[1:0], val[15:0]}
    function automatic logic [23:0] exp_step(input bit d2, input int i);
        logic [23:0] r;
        r = 24'h0;
        if (d2) begin
            case (i)
                0:  r = {6'b001000, 2'd0, 16'h0000};
                1:  r = {6'b010000, 2'd2, 16'h0000};
                2:  r = {6'b100000, 2'd3, 16'h0000};
                3:  r = {6'b000010, 2'd1, 16'h0000};
                4:  r = {6'b000001, 2'd0, 16'h0100};
                5:  r = {6'b001000, 2'd0, 16'h0000};
                6:  r = {6'b000100, 2'd0, 16'h0000};
                7:  r = {6'b000100, 2'd0, 16'h0000};
                8:  r = {6'b000001, 2'd0, 16'h0A33};
                9:  r = {6'b000010, 2'd1, 16'h0382};
                10: r = {6'b000010, 2'd1, 16'h0402};
                default: r = 24'h0;
            endcase
        end else begin
            case (i)
                0: r = {6'b001000, 2'd0, 16'h0000};
                1: r = {6'b000001, 2'd0, 16'h0133};
                2: r = {6'b000010, 2'd1, 16'h0002};
                3: r = {6'b001000, 2'd0, 16'h0000};
                4: r = {6'b000001, 2'd0, 16'h0033};
                default: r = 24'h0;
            endcase
        end
        return r;
    endfunction

    function automatic int exp_len(input bit d2);
        return d2 ? 11 : 5;
    endfunction

    function automatic logic [15:0] exp_refresh(input bit r40);
        return 16'h4000 | (r40 ? 16'd624 : 16'd390);
    endfunction

    task automatic check_idle(input string why);
        check(!init_done && !cmd_valid && cmd_code == 6'd0 && !ddr2_cfg_we && !refresh_we,
              "R7", why, {init_done, cmd_valid, ddr2_cfg_we, refresh_we, 2'b00, cmd_code}, 32'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0; cmd_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_idle("outputs during reset");
        rst = 1'b0;
        @(negedge clk);
        check_idle("outputs after reset");
    endtask

    task automatic run_seq(input bit d2, input bit r40, input bit noisy);
        int k, hold, wt, seen_cfg, seen_ref, n;
        bit prev_done;
        logic [23:0] cur, obs;
        string tag;
        tag = d2 ? "R2" : "R3";
        n = exp_len(d2);
        k = 0; hold = 0; wt = 0; seen_cfg = 0; seen_ref = 0; prev_done = 1'b0; cur = '0;
        @(negedge clk);
        strap_ddr2 = d2; strap_ref40 = r40; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 3000 && !init_done; c++) begin
            cmd_done = 1'b0;
            if (noisy) begin
                strap_ddr2  = 1'($urandom % 2);   // R8: straps wiggle mid-run
                strap_ref40 = 1'($urandom % 2);
            end
            if (ddr2_cfg_we) begin
                seen_cfg++;
                check(d2 && k == 0 && ddr2_cfg_word == 16'h0A59, "R4",
                      "config word before first command", ddr2_cfg_word, 16'h0A59);
            end
            if (refresh_we) begin
                seen_ref++;
                check(k == n, "R5", "refresh strobe after last command", k, n);
                check(refresh_word == exp_refresh(r40), "R5", "refresh word",
                      refresh_word, exp_refresh(r40));
            end
            obs = {cmd_code, mode_sel, mode_val};
            if (cmd_valid) begin
                if (prev_done) check(1'b0, "R6", "valid low after done", 1, 0);
                if (hold == 0) begin
                    check(k < n, tag, "command count", k, n);
                    check(obs == exp_step(d2, k), tag, $sformatf("step %0d", k),
                          obs, exp_step(d2, k));
                    check($onehot(cmd_code), "R1", "one-hot code", cmd_code, 0);
                    check(d2 || seen_cfg == 0, "R4", "no config before command", seen_cfg, 0);
                    cur = obs;
                    wt  = int'($urandom % 4);
                end else begin
                    check(obs == cur, "R6", "command held", obs, cur);
                end
                if (hold == wt) begin
                    cmd_done = 1'b1; k++; hold = 0; prev_done = 1'b1;
                end else begin
                    hold++; prev_done = 1'b0;
                end
            end else begin
                prev_done = 1'b0;
                check(cmd_code == 6'd0, "R1", "code zero when idle", cmd_code, 0);
                if (noisy && ($urandom % 2 == 1)) cmd_done = 1'b1;   // R6: stray done
            end
            @(negedge clk);
        end
        cmd_done = 1'b0;
        check(init_done, "R9", "init_done raised", init_done, 1);
        check(k == n, tag, "total commands", k, n);
        check(seen_ref == 1, "R5", "one refresh strobe", seen_ref, 1);
        check(seen_cfg == (d2 ? 1 : 0), "R4", "config strobe count", seen_cfg, d2 ? 1 : 0);
        check(refresh_word == exp_refresh(r40), "R5", "refresh word held", refresh_word,
              exp_refresh(r40));
    endtask

    task automatic after_done_pokes();
        for (int i = 0; i < 6; i++) begin
            start = 1'(i % 2);
            cmd_done = 1'(i % 3 == 0);
            @(negedge clk);
            check(init_done && !cmd_valid && !ddr2_cfg_we && !refresh_we, "R9",
                  "stays done, start ignored", {init_done, cmd_valid}, 2'b10);
        end
        start = 1'b0; cmd_done = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; start = 1'b0; strap_ddr2 = 1'b0; strap_ref40 = 1'b0; cmd_done = 1'b0;
        do_reset();

        // R6: done pulses while idle do nothing
        for (int i = 0; i < 3; i++) begin
            cmd_done = 1'b1;
            @(negedge clk);
            cmd_done = 1'b0;
            check_idle("idle ignores done");
        end

        // directed: all four strap combinations, no noise
        for (int m = 0; m < 4; m++) begin
            run_seq(1'(m / 2), 1'(m % 2), 1'b0);
            after_done_pokes();
            do_reset();
        end

        // R7: reset in the middle of a DDR2 script
        @(negedge clk);
        strap_ddr2 = 1'b1; strap_ref40 = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) @(negedge clk);
        check(cmd_valid, "R2", "command pending before reset", cmd_valid, 1);
        do_reset();

        // randomized runs with strap and done noise
        for (int r = 0; r < 8; r++) begin
            run_seq(1'($urandom % 2), 1'($urandom % 2), 1'b1);
            do_reset();
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule